// File: doc/BRIEF.md
# Stream-to-Memory DMA Write Channel

This block moves a packet arriving on an AXI4-Stream slave port into memory, one beat per address. Software programs it through a small AXI4-Lite style register port: a control word carrying a run bit, three interrupt enables and a threshold field, a destination address, and a byte count. Writing the byte count is what launches the transfer. The destination and the run bit must already be in place when that write arrives. While a transfer is active the stream port accepts data. Each accepted beat is written in the same cycle through a plain memory write port, and the address then advances by one beat width.

A transfer finishes on the first of two events: the accepted byte count reaches the programmed length, or a beat carries TLAST. If the source's packet size and the programmed count disagree, the channel still returns to idle. After completion the length register reports the number of bytes actually stored. A sticky completion flag is set, and it drives the interrupt output when its enable is on. Outside a transfer the stream sees back-pressure. A length write that cannot start a transfer leaves the channel untouched and sets a sticky rejection flag.

Top module: `s2mm_dma_channel`

## Requirements
- R1: After reset the control word reads 0, status reads 0x00000001 (halted only), s_tready is low and irq is low.
- R2: Register byte addresses are control 0x30, status 0x34, destination 0x48 and length 0x58. The control word keeps bit 0 (run), bits 12/13/14 (completion, delay and error interrupt enables) and bits 23:16 (threshold) and reads all other bits as zero, so writing 0x00017001 reads back 0x00017001. The destination reads back as written, with its beat-offset bits cleared.
- R3: s_tready is low unless a transfer is active. A length write that starts a transfer raises s_tready in the cycle after the write handshake.
- R4: Each accepted beat (s_tvalid and s_tready both high) asserts mem_we in that same cycle, with mem_wdata equal to s_tdata and mem_addr equal to the destination plus 4 times the beat index.
- R5: With no TLAST, a transfer ends on the beat that brings the accepted byte count (4 bytes per beat) to or past the programmed length. s_tready is low from the next cycle on.
- R6: A beat with s_tlast high ends the transfer even if fewer bytes than programmed have arrived. After any completion the length register reads the number of bytes written.
- R7: On completion, status bit 12 (complete) and bit 1 (idle, meaning run set and no transfer active) read 1. Writing 1 to status bit 12 clears it. Writing 0 leaves it set.
- R8: irq equals status bit 12 ANDed with control bit 12.
- R9: A length write while a transfer is active, while run is 0, or with value 0 starts nothing. s_tready stays as it was, the active transfer keeps its length, and status bit 4 is set. Bit 4 is cleared by writing 1 to it. Status bit 0 (halted) reads 1 when run is 0 and no transfer is active.
- R10: Transfers of 32 bytes and of 1024 bytes both complete, and transfers can follow one another without reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_awvalid | input | 1 | Register write address valid |
| reg_awready | output | 1 | Register write address ready |
| reg_awaddr | input | REG_AW | Register write byte address |
| reg_wvalid | input | 1 | Register write data valid |
| reg_wready | output | 1 | Register write data ready |
| reg_wdata | input | 32 | Register write data |
| reg_bvalid | output | 1 | Write response valid |
| reg_bready | input | 1 | Write response ready |
| reg_arvalid | input | 1 | Register read address valid |
| reg_arready | output | 1 | Register read address ready |
| reg_araddr | input | REG_AW | Register read byte address |
| reg_rvalid | output | 1 | Read data valid |
| reg_rready | input | 1 | Read data ready |
| reg_rdata | output | 32 | Read data |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Stream beat ready |
| s_tdata | input | DATA_W | Stream beat data |
| s_tlast | input | 1 | Last beat of stream packet |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | MEM_AW | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions take four things for granted about the inputs. The write address and write data of a register write arrive together. The memory port accepts a write every cycle. The programmed length leaves at least one beat of headroom below the top of the length range. Software supplies beat-aligned destinations. The stimulus presents address and data in a single write task, models memory as always ready, and draws lengths of 1 to 32 beats plus fixed 32-byte and 1024-byte cases. Stream gaps and TLAST positions are random, and some TLAST positions fall past the programmed length so that both ending conditions occur.

// File: rtl/s2mm_pkg.sv
// Package: shared register offsets and bit positions for the stream-to-memory
// write channel. Assumes byte addressing on the register port.
package s2mm_pkg;
    localparam logic [7:0] OFS_CTRL = 8'h30;
    localparam logic [7:0] OFS_STAT = 8'h34;
    localparam logic [7:0] OFS_DEST = 8'h48;
    localparam logic [7:0] OFS_LEN  = 8'h58;

    localparam int CTRL_RUN    = 0;
    localparam int CTRL_IE_CPL = 12;
    localparam int CTRL_IE_DLY = 13;
    localparam int CTRL_IE_ERR = 14;
    localparam logic [31:0] CTRL_KEEP = 32'h00FF_7001;

    localparam int STAT_HALT = 0;
    localparam int STAT_IDLE = 1;
    localparam int STAT_REJ  = 4;
    localparam int STAT_CPL  = 12;
endpackage

// File: rtl/s2mm_regfile.sv
// Module: register port and software-visible state.
// Decodes the lite-style register port, holds control/destination/length,
// launches transfers on a length write and keeps the sticky flags.
// Assumes write address and write data are presented together.
module s2mm_regfile
    import s2mm_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int MEM_AW = 32,
    parameter int LEN_W  = 16,
    parameter int BEAT_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              awvalid,
    output logic              awready,
    input  logic [REG_AW-1:0] awaddr,
    input  logic              wvalid,
    output logic              wready,
    input  logic [31:0]       wdata,
    output logic              bvalid,
    input  logic              bready,
    input  logic              arvalid,
    output logic              arready,
    input  logic [REG_AW-1:0] araddr,
    output logic              rvalid,
    input  logic              rready,
    output logic [31:0]       rdata,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic [LEN_W-1:0]  eng_bytes,
    output logic              start,
    output logic [MEM_AW-1:0] start_dest,
    output logic [LEN_W-1:0]  start_len,
    output logic              irq
);
    localparam logic [MEM_AW-1:0] ALIGN_MASK = ~MEM_AW'(BEAT_BYTES - 1);

    logic [31:0]       ctrl_q;
    logic [MEM_AW-1:0] dest_q;
    logic [LEN_W-1:0]  len_q;
    logic              cpl_q, rej_q;
    logic              bvalid_q, rvalid_q;
    logic [31:0]       rdata_q;
    logic              wr_fire, rd_fire, len_wr, reject;
    logic [31:0]       stat_v, rd_val;

    // handshake qualifiers for both directions
    assign wr_fire = awvalid && wvalid && !bvalid_q;
    assign rd_fire = arvalid && !rvalid_q;
    assign awready = !bvalid_q;
    assign wready  = !bvalid_q;
    assign arready = !rvalid_q;
    assign bvalid  = bvalid_q;
    assign rvalid  = rvalid_q;
    assign rdata   = rdata_q;

    // transfer launch decision on a length write
    assign len_wr     = wr_fire && (awaddr == REG_AW'(OFS_LEN));
    assign start      = len_wr && ctrl_q[CTRL_RUN] && !eng_busy && (wdata[LEN_W-1:0] != '0);
    assign reject     = len_wr && !start;
    assign start_dest = dest_q;
    assign start_len  = wdata[LEN_W-1:0];
    assign irq        = cpl_q && ctrl_q[CTRL_IE_CPL];

    // status word assembly
    always_comb begin
        stat_v = '0;
        stat_v[STAT_HALT] = !ctrl_q[CTRL_RUN] && !eng_busy;
        stat_v[STAT_IDLE] = ctrl_q[CTRL_RUN] && !eng_busy;
        stat_v[STAT_REJ]  = rej_q;
        stat_v[STAT_CPL]  = cpl_q;
    end

    // read data selection
    always_comb begin
        rd_val = '0;
        if (araddr == REG_AW'(OFS_CTRL))      rd_val = ctrl_q;
        else if (araddr == REG_AW'(OFS_STAT)) rd_val = stat_v;
        else if (araddr == REG_AW'(OFS_DEST)) rd_val = 32'(dest_q);
        else if (araddr == REG_AW'(OFS_LEN))  rd_val = 32'(len_q);
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            dest_q <= '0;
            len_q  <= '0;
        end else begin
            if (wr_fire && awaddr == REG_AW'(OFS_CTRL)) ctrl_q <= wdata & CTRL_KEEP;
            if (wr_fire && awaddr == REG_AW'(OFS_DEST)) dest_q <= wdata[MEM_AW-1:0] & ALIGN_MASK;
            if (start)         len_q <= start_len;
            else if (eng_done) len_q <= eng_bytes;
        end
    end

    // sticky completion and rejection flags, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpl_q <= 1'b0;
            rej_q <= 1'b0;
        end else begin
            if (eng_done) cpl_q <= 1'b1;
            else if (wr_fire && awaddr == REG_AW'(OFS_STAT) && wdata[STAT_CPL]) cpl_q <= 1'b0;
            if (reject) rej_q <= 1'b1;
            else if (wr_fire && awaddr == REG_AW'(OFS_STAT) && wdata[STAT_REJ]) rej_q <= 1'b0;
        end
    end

    // response channels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bvalid_q <= 1'b0;
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            if (wr_fire)     bvalid_q <= 1'b1;
            else if (bready) bvalid_q <= 1'b0;
            if (rd_fire) begin
                rvalid_q <= 1'b1;
                rdata_q  <= rd_val;
            end else if (rready) begin
                rvalid_q <= 1'b0;
            end
        end
    end

    AST_CPL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n) eng_done |=> cpl_q); // R7
    AST_REJ_SET: assert property (@(posedge clk) disable iff (!rst_n) (len_wr && eng_busy) |=> rej_q); // R9
    AST_LEN_REPORT: assert property (@(posedge clk) disable iff (!rst_n) eng_done |=> (len_q == $past(eng_bytes))); // R6
endmodule

// File: rtl/s2mm_xfer_engine.sv
// Module: transfer engine.
// Accepts stream beats while a transfer is active, writes each one to memory
// in the same cycle, advances the address and ends on TLAST or byte count.
// Assumes memory never stalls and lengths stay a beat below the counter top.
module s2mm_xfer_engine #(
    parameter int DATA_W = 32,
    parameter int MEM_AW = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MEM_AW-1:0] start_dest,
    input  logic [LEN_W-1:0]  start_len,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tlast,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output logic [LEN_W-1:0]  done_bytes
);
    localparam int BEAT_BYTES = DATA_W / 8;

    logic              busy_q;
    logic [MEM_AW-1:0] addr_q;
    logic [LEN_W:0]    len_q, cnt_q, cnt_nxt;
    logic              beat, fin;

    // beat acceptance and end-of-transfer detection
    assign beat       = s_tvalid && busy_q;
    assign cnt_nxt    = cnt_q + (LEN_W+1)'(BEAT_BYTES);
    assign fin        = beat && (s_tlast || cnt_nxt >= len_q);
    assign s_tready   = busy_q;
    assign busy       = busy_q;
    assign done       = fin;
    assign done_bytes = cnt_nxt[LEN_W-1:0];
    assign mem_we     = beat;
    assign mem_addr   = addr_q;
    assign mem_wdata  = s_tdata;

    // transfer state: active flag, address and byte count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            addr_q <= '0;
            len_q  <= '0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            addr_q <= start_dest;
            len_q  <= {1'b0, start_len};
            cnt_q  <= '0;
        end else if (beat) begin
            addr_q <= addr_q + MEM_AW'(BEAT_BYTES);
            cnt_q  <= cnt_nxt;
            if (fin) busy_q <= 1'b0;
        end
    end

    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n) start |-> !busy_q); // R9
    AST_READY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) start |=> s_tready); // R3
    AST_DONE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n) done |=> !s_tready); // R5
    AST_CNT_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n) busy_q |-> (cnt_q < len_q)); // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && $past(beat) && !$past(fin)) |-> (mem_addr == $past(mem_addr) + MEM_AW'(BEAT_BYTES))); // R4
endmodule

// File: rtl/s2mm_dma_channel.sv
// Module: stream-to-memory DMA write channel, top level.
// Joins the register block and the transfer engine. Assumes a byte-addressed
// register window of at least 8 address bits and MEM_AW no wider than 32.
module s2mm_dma_channel #(
    parameter int REG_AW = 8,
    parameter int DATA_W = 32,
    parameter int MEM_AW = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_awvalid,
    output logic              reg_awready,
    input  logic [REG_AW-1:0] reg_awaddr,
    input  logic              reg_wvalid,
    output logic              reg_wready,
    input  logic [31:0]       reg_wdata,
    output logic              reg_bvalid,
    input  logic              reg_bready,
    input  logic              reg_arvalid,
    output logic              reg_arready,
    input  logic [REG_AW-1:0] reg_araddr,
    output logic              reg_rvalid,
    input  logic              reg_rready,
    output logic [31:0]       reg_rdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tlast,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              irq
);
    localparam int BEAT_BYTES = DATA_W / 8;

    logic              start, eng_busy, eng_done;
    logic [MEM_AW-1:0] start_dest;
    logic [LEN_W-1:0]  start_len, eng_bytes;

    s2mm_regfile #(
        .REG_AW(REG_AW), .MEM_AW(MEM_AW), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .awvalid(reg_awvalid), .awready(reg_awready), .awaddr(reg_awaddr),
        .wvalid(reg_wvalid), .wready(reg_wready), .wdata(reg_wdata),
        .bvalid(reg_bvalid), .bready(reg_bready),
        .arvalid(reg_arvalid), .arready(reg_arready), .araddr(reg_araddr),
        .rvalid(reg_rvalid), .rready(reg_rready), .rdata(reg_rdata),
        .eng_busy(eng_busy), .eng_done(eng_done), .eng_bytes(eng_bytes),
        .start(start), .start_dest(start_dest), .start_len(start_len),
        .irq(irq)
    );

    s2mm_xfer_engine #(
        .DATA_W(DATA_W), .MEM_AW(MEM_AW), .LEN_W(LEN_W)
    ) u_engine (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_dest(start_dest), .start_len(start_len),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tlast(s_tlast),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(eng_busy), .done(eng_done), .done_bytes(eng_bytes)
    );

    AST_READY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(s_tready) |-> $past(start)); // R3
    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> s_tready); // R4
endmodule

// File: tb/s2mm_dma_channel_bench.sv
module s2mm_dma_channel_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_awvalid = 0, reg_wvalid = 0, reg_bready = 1, reg_arvalid = 0, reg_rready = 1;
    logic reg_awready, reg_wready, reg_bvalid, reg_arready, reg_rvalid;
    logic [7:0] reg_awaddr = 0, reg_araddr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic s_tvalid = 0, s_tlast = 0, s_tready;
    logic [31:0] s_tdata = 0;
    logic mem_we, irq;
    logic [31:0] mem_addr, mem_wdata;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    s2mm_dma_channel u_s2mm_dma_channel (
        .clk(clk), .rst_n(rst_n),
        .reg_awvalid(reg_awvalid), .reg_awready(reg_awready), .reg_awaddr(reg_awaddr),
        .reg_wvalid(reg_wvalid), .reg_wready(reg_wready), .reg_wdata(reg_wdata),
        .reg_bvalid(reg_bvalid), .reg_bready(reg_bready),
        .reg_arvalid(reg_arvalid), .reg_arready(reg_arready), .reg_araddr(reg_araddr),
        .reg_rvalid(reg_rvalid), .reg_rready(reg_rready), .reg_rdata(reg_rdata),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tlast(s_tlast),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_awvalid = 1; reg_wvalid = 1; reg_awaddr = a; reg_wdata = d;
        @(negedge clk);
        while (!reg_awready) @(negedge clk);
        @(posedge clk); #1;
        reg_awvalid = 0; reg_wvalid = 0;
        @(negedge clk);
        while (!reg_bvalid) @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_arvalid = 1; reg_araddr = a;
        @(negedge clk);
        while (!reg_arready) @(negedge clk);
        @(posedge clk); #1;
        reg_arvalid = 0;
        @(negedge clk);
        while (!reg_rvalid) @(negedge clk);
        d = reg_rdata;
        @(posedge clk); #1;
    endtask

    // Sends nb beats, TLAST on beat index li (none when li<0); checks each memory write.
    task automatic send(input logic [31:0] dest, input int nb, input int li, output int bad);
        bad = 0;
        for (int i = 0; i < nb; i++) begin
            for (int g = 0; g < int'($urandom % 3); g++) begin
                @(posedge clk); #1;
            end
            s_tvalid = 1; s_tdata = $urandom; s_tlast = (i == li);
            @(negedge clk);
            while (!s_tready) @(negedge clk);
            if (!mem_we || mem_addr !== dest + 32'(i * 4) || mem_wdata !== s_tdata) begin
                bad++;
                $display("FAIL R4 beat %0d got we=%b addr %h data %h exp addr %h data %h",
                         i, mem_we, mem_addr, mem_wdata, dest + 32'(i * 4), s_tdata);
            end
            @(posedge clk); #1;
            s_tvalid = 0; s_tlast = 0;
        end
    endtask

    function automatic int exp_beats(input int len_b, input int li);
        int nb = (len_b + 3) / 4;
        if (li >= 0 && li + 1 < nb) nb = li + 1;
        return nb;
    endfunction

    function automatic logic [31:0] exp_stat(input bit run, input bit rej, input bit cpl);
        return {19'd0, cpl, 7'd0, rej, 2'd0, run, !run};
    endfunction

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int bad, nb, li, lb;
        void'($urandom(32'd11));
        repeat (4) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        rd(8'h30, v); chk("R1 ctrl", v, 0);
        rd(8'h34, v); chk("R1 status", v, 32'h1);
        chk("R1 tready", {31'd0, s_tready}, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 register map and control mask
        wr(8'h30, 32'hFFFF_FFFF); rd(8'h30, v); chk("R2 ctrl mask", v, 32'h00FF_7001);
        wr(8'h30, 32'h0001_7001); rd(8'h30, v); chk("R2 ctrl value", v, 32'h0001_7001);
        wr(8'h48, 32'h0010_0003); rd(8'h48, v); chk("R2 dest align", v, 32'h0010_0000);

        // R3 back-pressure before a length write, ready after it
        repeat (3) @(posedge clk); @(negedge clk);
        chk("R3 idle tready", {31'd0, s_tready}, 0);
        @(posedge clk); #1;
        wr(8'h58, 32); @(negedge clk);
        chk("R3 tready on start", {31'd0, s_tready}, 1);
        @(posedge clk); #1;

        // R5 R10 32-byte transfer ends on count
        send(32'h0010_0000, 8, -1, bad); chk("R4 32B data", bad, 0);
        @(negedge clk); chk("R5 tready after end", {31'd0, s_tready}, 0);
        @(posedge clk); #1;
        rd(8'h58, v); chk("R10 32B length", v, 32);
        rd(8'h34, v); chk("R7 status done", v, exp_stat(1, 0, 1));
        chk("R8 irq set", {31'd0, irq}, 1);

        // R7 write-one-to-clear
        wr(8'h34, 0); rd(8'h34, v); chk("R7 zero keeps", v, exp_stat(1, 0, 1));
        wr(8'h34, 32'h1000); rd(8'h34, v); chk("R7 clear", v, exp_stat(1, 0, 0));
        chk("R8 irq clear", {31'd0, irq}, 0);

        // R10 1024 bytes
        wr(8'h48, 32'h0100_0000); wr(8'h58, 1024);
        send(32'h0100_0000, 256, -1, bad); chk("R10 1024B data", bad, 0);
        rd(8'h58, v); chk("R10 1024B length", v, 1024);
        wr(8'h34, 32'h1000);

        // R6 early TLAST
        wr(8'h58, 64);
        send(32'h0100_0000, 6, 5, bad); chk("R6 tlast data", bad, 0);
        @(negedge clk); chk("R6 tready after tlast", {31'd0, s_tready}, 0);
        @(posedge clk); #1;
        rd(8'h58, v); chk("R6 bytes reported", v, 24);
        wr(8'h34, 32'h1000);

        // R9 length write while busy
        wr(8'h58, 32); wr(8'h58, 64);
        rd(8'h34, v); chk("R9 busy reject", v, 32'h10);
        send(32'h0100_0000, 8, -1, bad);
        @(negedge clk); chk("R9 length kept", {31'd0, s_tready}, 0);
        @(posedge clk); #1;
        rd(8'h58, v); chk("R9 busy length", v, 32);
        wr(8'h34, 32'h1010); rd(8'h34, v); chk("R9 clear", v, exp_stat(1, 0, 0));

        // R9 halted
        wr(8'h30, 0); wr(8'h58, 16); @(negedge clk);
        chk("R9 halted tready", {31'd0, s_tready}, 0);
        @(posedge clk); #1;
        rd(8'h34, v); chk("R9 halted status", v, exp_stat(0, 1, 0));
        wr(8'h34, 32'h10);

        // R9 zero length
        wr(8'h30, 32'h1); wr(8'h58, 0); @(negedge clk);
        chk("R9 zero tready", {31'd0, s_tready}, 0);
        @(posedge clk); #1;
        rd(8'h34, v); chk("R9 zero status", v, exp_stat(1, 1, 0));
        wr(8'h34, 32'h10);

        // R8 completion with interrupt disabled
        wr(8'h58, 8); send(32'h0100_0000, 2, -1, bad);
        rd(8'h34, v); chk("R8 done no enable", v, exp_stat(1, 0, 1));
        chk("R8 irq masked", {31'd0, irq}, 0);
        wr(8'h34, 32'h1000);

        // random transfers: R4 R5 R6 R8 R10
        wr(8'h30, 32'h0001_7001);
        for (int t = 0; t < 10; t++) begin
            lb = (1 + int'($urandom % 32)) * 4;
            li = int'($urandom % 40) - 2;
            nb = exp_beats(lb, li);
            v = 32'h0200_0000 + 32'(t * 32'h1000);
            wr(8'h48, v); wr(8'h58, 32'(lb));
            send(v, nb, li, bad); chk("R4 random data", bad, 0);
            @(negedge clk); chk("R5 random end", {31'd0, s_tready}, 0);
            @(posedge clk); #1;
            rd(8'h58, v); chk("R6 random bytes", v, 32'(nb * 4));
            chk("R8 random irq", {31'd0, irq}, 1);
            wr(8'h34, 32'h1000);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule